// File: doc/BRIEF.md
# Codec Slave Frame Synchronizer

This block is the framing engine for a serial codec port that works as a frame-sync slave. The attached codec supplies the bit clock, which is the block's `clk`, and the frame-sync line. The block samples frame sync on the rising bit-clock edge and decides whether a frame begins. The rule depends on the selected mode. Multi-channel and AC-link modes look for a sampled high level. I2S mode looks for either transition of the line.

Once a frame has been accepted, the block runs the whole frame:
- it moves a programmed number of words, each of a programmed length;
- it shifts transmit words out MSB first on `sdo`;
- it captures `sdi` into a receive shifter and reports each finished word in parallel;
- it ignores further syncs until the frame ends.

In AC-link mode the first word of the frame is a full-width tag slot. The remaining words use the programmed length.

The configuration is taken when a frame starts. A sync seen on the final edge of a frame starts the next frame with no gap, so I2S streams run back to back.

Top module: `codec_slave_framer`

## Requirements
- R1: After reset, `sdo`, `frame_active`, `frame_done`, `rx_valid` and `tx_take` are all 0.
- R2: Modes are encoded on `cfg_mode` as 00 multi-channel, 01 I2S and 10 AC-link. In modes 00 and 10, if `fsync` is sampled high at rising edge n, `frame_active` is 1 and `sdo` carries the MSB of word 0 after edge n+1.
- R3: In mode 01, a rising or a falling change of `fsync` between two samples starts a frame one edge after the second sample.
- R4: In mode 10, word 0 of each frame is MAX_WORD_BITS (16) bits long, and the other words use the configured length.
- R5: Each transmit word is sent MSB first, one bit per bit-clock period. `tx_word` is latched at the edge that drives that word's first bit, and `tx_take` is 1 for the cycle that follows each latch.
- R6: `sdi` is sampled on the falling edge of each bit period. At the rising edge that closes a word's last bit, `rx_valid` pulses for one cycle and `rx_word` holds the word right-justified, MSB first.
- R7: A sync seen while a frame is active is ignored, except on the edge that closes the frame's last bit.
- R8: At the edge that closes the last bit of the last word, `frame_done` pulses for one cycle. `frame_active` then clears, unless a sync accepted on that same edge starts the next frame at once.
- R9: Mode, word length and word count are latched when a frame starts. Changing them during the frame alters neither the frame's length nor its bits.
- R10: The word length is clamped to the range 4..16 and the word count to the range 1..16.
- R11: Mode 11 is reserved and never starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Sync mode: 00 multi-channel, 01 I2S, 10 AC-link, 11 reserved |
| cfg_word_bits | input | 5 | Bits per word (clamped to 4..16) |
| cfg_words | input | 5 | Words per frame (clamped to 1..16) |
| fsync | input | 1 | Frame-sync line from the codec |
| sdi | input | 1 | Serial receive data |
| tx_word | input | 16 | Next transmit word, right-justified |
| sdo | output | 1 | Serial transmit data, 0 when idle |
| tx_take | output | 1 | `tx_word` was latched on the previous edge |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_word | output | 16 | Received word, right-justified |
| frame_active | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench places a second sync pulse in the middle of a multi-channel frame. A design without the lockout would restart, and both `sdo` and the frame length would go wrong.

It chains two I2S frames. The first starts on a rising edge of `fsync` and the second on a falling edge, timed to land exactly on the closing edge of the first. A design that only detects rising edges, or that refuses a sync on the final edge, would drop the second frame or leave a gap cycle.

The configuration is changed in the middle of every frame. Out-of-range settings are driven to check the clamps, AC-link frames check that the tag slot is full width, and the reserved mode is pulsed to check that no frame starts. A design that used the live settings would shorten the frame or misalign its bits.

// File: rtl/csf_pkg.sv
package csf_pkg;
   typedef enum logic [1:0] {
      CSF_MULTI  = 2'b00,
      CSF_I2S    = 2'b01,
      CSF_ACLINK = 2'b10,
      CSF_RSVD   = 2'b11
   } csf_mode_e;
endpackage

// File: rtl/csf_sync_detect.sv
// Samples frame sync on the bit clock and flags a frame-start request
module csf_sync_detect
   import csf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fsync,
   input  logic [1:0] cfg_mode,
   output logic       sync_hit
);
   logic fs_q;
   logic fs_prev;
   csf_mode_e mode;

   assign mode = csf_mode_e'(cfg_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q    <= 1'b0;
         fs_prev <= 1'b0;
      end else begin
         fs_q    <= fsync;
         fs_prev <= fs_q;
      end
   end

   always_comb begin
      unique case (mode)
         CSF_MULTI, CSF_ACLINK: sync_hit = fs_q;
         CSF_I2S:               sync_hit = fs_q ^ fs_prev;
         default:               sync_hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/csf_frame_seq.sv
// Bit/word sequencer: start acceptance, lockout, configuration latch
module csf_frame_seq
   import csf_pkg::*;
#(
   parameter int MAXW   = 16,
   parameter int MINW   = 4,
   parameter int MAXN   = 16,
   parameter int LEN_W  = 5,
   parameter int WCNT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_hit,
   input  logic [1:0]        cfg_mode,
   input  logic [LEN_W-1:0]  cfg_word_bits,
   input  logic [WCNT_W-1:0] cfg_words,
   output logic              start,
   output logic              word_end,
   output logic              frame_end,
   output logic              frame_active,
   output logic [LEN_W-1:0]  cur_len,
   output logic [LEN_W-1:0]  load_len,
   output logic [LEN_W-1:0]  lat_len
);
   logic [LEN_W-1:0]  bit_idx;
   logic [WCNT_W-1:0] word_idx;
   logic [WCNT_W-1:0] words_q;
   logic              ac_q;
   logic [LEN_W-1:0]  start_len;

   function automatic logic [LEN_W-1:0] clamp_bits(input logic [LEN_W-1:0] v);
      if (int'(v) < MINW)      return LEN_W'(MINW);
      else if (int'(v) > MAXW) return LEN_W'(MAXW);
      else                     return v;
   endfunction

   function automatic logic [WCNT_W-1:0] clamp_words(input logic [WCNT_W-1:0] v);
      if (int'(v) < 1)         return WCNT_W'(1);
      else if (int'(v) > MAXN) return WCNT_W'(MAXN);
      else                     return v;
   endfunction

   assign cur_len   = (ac_q && word_idx == '0) ? LEN_W'(MAXW) : lat_len;
   assign word_end  = frame_active && (bit_idx == cur_len - 1'b1);
   assign frame_end = word_end && (word_idx == words_q - 1'b1);
   assign start     = sync_hit && (!frame_active || frame_end);
   assign start_len = (csf_mode_e'(cfg_mode) == CSF_ACLINK) ? LEN_W'(MAXW)
                                                            : clamp_bits(cfg_word_bits);
   assign load_len  = start ? start_len : lat_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_active <= 1'b0;
         bit_idx      <= '0;
         word_idx     <= '0;
         words_q      <= '0;
         lat_len      <= '0;
         ac_q         <= 1'b0;
      end else if (start) begin
         frame_active <= 1'b1;
         bit_idx      <= '0;
         word_idx     <= '0;
         words_q      <= clamp_words(cfg_words);
         lat_len      <= clamp_bits(cfg_word_bits);
         ac_q         <= (csf_mode_e'(cfg_mode) == CSF_ACLINK);
      end else if (frame_end) begin
         frame_active <= 1'b0;
      end else if (word_end) begin
         bit_idx      <= '0;
         word_idx     <= word_idx + 1'b1;
      end else if (frame_active) begin
         bit_idx      <= bit_idx + 1'b1;
      end
   end
endmodule

// File: rtl/csf_shifter.sv
// Transmit and receive shift registers; RX_ON_FALL picks the sdi sample edge
module csf_shifter #(
   parameter int MAXW       = 16,
   parameter int LEN_W      = 5,
   parameter bit RX_ON_FALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sdi,
   input  logic             load,
   input  logic [MAXW-1:0]  load_word,
   input  logic [LEN_W-1:0] load_len,
   input  logic             active,
   input  logic             word_end,
   input  logic [LEN_W-1:0] word_len,
   output logic             tx_msb,
   output logic             tx_take,
   output logic             rx_valid,
   output logic [MAXW-1:0]  rx_word
);
   logic [MAXW-1:0] tx_sh;
   logic [MAXW-2:0] rx_sh;
   logic [MAXW-1:0] rx_next;
   logic [MAXW-1:0] tx_aligned;
   logic            rx_bit;

   function automatic logic [MAXW-1:0] len_mask(input logic [LEN_W-1:0] len);
      return {MAXW{1'b1}} >> (MAXW - int'(len));
   endfunction

   generate
      if (RX_ON_FALL) begin : g_rx_fall
         logic sdi_fall;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) sdi_fall <= 1'b0;
            else        sdi_fall <= sdi;
         end
         assign rx_bit = sdi_fall;
      end else begin : g_rx_rise
         assign rx_bit = sdi;
      end
   endgenerate

   assign tx_aligned = (load_word & len_mask(load_len)) << (MAXW - int'(load_len));
   assign tx_msb     = tx_sh[MAXW-1];
   assign rx_next    = {rx_sh, rx_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh    <= '0;
         rx_sh    <= '0;
         rx_word  <= '0;
         rx_valid <= 1'b0;
         tx_take  <= 1'b0;
      end else begin
         tx_take  <= load;
         rx_valid <= word_end;
         if (load)        tx_sh <= tx_aligned;
         else if (active) tx_sh <= {tx_sh[MAXW-2:0], 1'b0};
         if (active)      rx_sh <= rx_next[MAXW-2:0];
         if (word_end)    rx_word <= rx_next & len_mask(word_len);
      end
   end
endmodule

// File: rtl/codec_slave_framer.sv
module codec_slave_framer
   import csf_pkg::*;
#(
   parameter int MAX_WORD_BITS = 16,
   parameter int MIN_WORD_BITS = 4,
   parameter int MAX_WORDS     = 16,
   parameter bit RX_ON_FALL    = 1'b1,
   localparam int LEN_W  = $clog2(MAX_WORD_BITS + 1),
   localparam int WCNT_W = $clog2(MAX_WORDS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               cfg_mode,
   input  logic [LEN_W-1:0]         cfg_word_bits,
   input  logic [WCNT_W-1:0]        cfg_words,
   input  logic                     fsync,
   input  logic                     sdi,
   input  logic [MAX_WORD_BITS-1:0] tx_word,
   output logic                     sdo,
   output logic                     tx_take,
   output logic                     rx_valid,
   output logic [MAX_WORD_BITS-1:0] rx_word,
   output logic                     frame_active,
   output logic                     frame_done
);
   generate
      if (MIN_WORD_BITS < 2 || MIN_WORD_BITS > MAX_WORD_BITS) begin : g_bad_minw
         $error("MIN_WORD_BITS out of range");
      end
      if (MAX_WORDS < 1) begin : g_bad_words
         $error("MAX_WORDS must be at least 1");
      end
   endgenerate

   logic             sync_hit;
   logic             start;
   logic             word_end;
   logic             frame_end;
   logic             tx_msb;
   logic [LEN_W-1:0] cur_len;
   logic [LEN_W-1:0] load_len;
   logic [LEN_W-1:0] lat_len;
   logic             load;

   csf_sync_detect u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsync    (fsync),
      .cfg_mode (cfg_mode),
      .sync_hit (sync_hit)
   );

   csf_frame_seq #(
      .MAXW(MAX_WORD_BITS), .MINW(MIN_WORD_BITS), .MAXN(MAX_WORDS),
      .LEN_W(LEN_W), .WCNT_W(WCNT_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .sync_hit      (sync_hit),
      .cfg_mode      (cfg_mode),
      .cfg_word_bits (cfg_word_bits),
      .cfg_words     (cfg_words),
      .start         (start),
      .word_end      (word_end),
      .frame_end     (frame_end),
      .frame_active  (frame_active),
      .cur_len       (cur_len),
      .load_len      (load_len),
      .lat_len       (lat_len)
   );

   assign load = start || (word_end && !frame_end);

   csf_shifter #(
      .MAXW(MAX_WORD_BITS), .LEN_W(LEN_W), .RX_ON_FALL(RX_ON_FALL)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sdi       (sdi),
      .load      (load),
      .load_word (tx_word),
      .load_len  (load_len),
      .active    (frame_active),
      .word_end  (word_end),
      .word_len  (cur_len),
      .tx_msb    (tx_msb),
      .tx_take   (tx_take),
      .rx_valid  (rx_valid),
      .rx_word   (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_done <= 1'b0;
      else        frame_done <= frame_end;
   end

   assign sdo = frame_active & tx_msb;
endmodule

// File: rtl/csf_checker.sv
module csf_checker #(
   parameter int LEN_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_mode,
   input logic             frame_active,
   input logic             frame_done,
   input logic             rx_valid,
   input logic             tx_take,
   input logic [LEN_W-1:0] lat_len
);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   p_done_after_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(frame_active));

   p_done_with_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> rx_valid);

   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_take_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_active) |-> tx_take);

   p_rsvd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_active && cfg_mode == 2'b11) |=> !frame_active);

   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_active && !tx_take) |-> $stable(lat_len));
endmodule

bind codec_slave_framer csf_checker #(.LEN_W(LEN_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_mode     (cfg_mode),
   .frame_active (frame_active),
   .frame_done   (frame_done),
   .rx_valid     (rx_valid),
   .tx_take      (tx_take),
   .lat_len      (lat_len)
);

// File: tb/sim_codec_slave_framer.sv
`timescale 1ns/1ps
module sim_codec_slave_framer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_mode = 2'b00;
   logic [4:0]  cfg_word_bits = 5'd8;
   logic [4:0]  cfg_words = 5'd1;
   logic        fsync = 1'b0;
   logic        sdi = 1'b0;
   logic [15:0] tx_word = '0;
   logic        sdo, tx_take, rx_valid, frame_active, frame_done;
   logic [15:0] rx_word;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   codec_slave_framer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_word_bits(cfg_word_bits),
      .cfg_words(cfg_words), .fsync(fsync), .sdi(sdi), .tx_word(tx_word),
      .sdo(sdo), .tx_take(tx_take), .rx_valid(rx_valid), .rx_word(rx_word),
      .frame_active(frame_active), .frame_done(frame_done)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic int clampi(input int v, input int lo, input int hi);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   function automatic int gen_w(input int seed, input int k, input int len);
      return ((seed * 949 + k * 467 + 90) ^ (k << 7)) & ((1 << len) - 1);
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // One full frame; chained: start edge already passed; chain_next: I2S toggle
   // timed so the next frame starts on this frame's closing edge
   task automatic run_frame(input string rq, input logic [1:0] md, input int raw_bits,
                            input int raw_words, input int seed, input bit chained,
                            input bit chain_next, input int pulse_at);
      int lb = clampi(raw_bits, 4, 16);
      int wn = clampi(raw_words, 1, 16);
      int ntot = 0;
      int j = 0;
      int lastlen = 0;
      for (int k = 0; k < wn; k++) ntot += (md == 2'b10 && k == 0) ? 16 : lb;
      if (!chained) begin
         cfg_mode = md; cfg_word_bits = 5'(raw_bits); cfg_words = 5'(raw_words);
         tx_word = 16'(gen_w(seed, 0, (md == 2'b10) ? 16 : lb));
         step();
         if (md == 2'b01) fsync = ~fsync; else fsync = 1'b1;
         step();
         if (md != 2'b01) fsync = 1'b0;
      end
      for (int k = 0; k < wn; k++) begin
         int lk = (md == 2'b10 && k == 0) ? 16 : lb;
         int txv = gen_w(seed, k, lk);
         int rxv = gen_w(seed + 100, k, lk);
         for (int b = 0; b < lk; b++) begin
            if (!(chained && j == 0)) step();
            chk("R5", "sdo bit", int'(sdo), (txv >> (lk - 1 - b)) & 1);
            chk((j == 0) ? rq : "R9", "frame_active", int'(frame_active), 1);
            if (b == 0) begin
               chk("R5", "tx_take", int'(tx_take), 1);
               if (k > 0) begin
                  int plen = (md == 2'b10 && k == 1) ? 16 : lb;
                  chk("R6", "rx_valid", int'(rx_valid), 1);
                  chk("R6", "rx_word", int'(rx_word), gen_w(seed + 100, k - 1, plen));
               end
               if (k + 1 < wn) tx_word = 16'(gen_w(seed, k + 1, lb));
               else            tx_word = 16'(gen_w(seed + 1, 0, lb));
            end else begin
               chk("R6", "rx_valid idle", int'(rx_valid), 0);
               chk("R5", "tx_take idle", int'(tx_take), 0);
            end
            sdi = 1'((rxv >> (lk - 1 - b)) & 1);
            if (j == 1) begin cfg_word_bits = 5'd9; cfg_words = 5'd2; end
            if (j == ntot - 2) begin cfg_word_bits = 5'(raw_bits); cfg_words = 5'(raw_words); end
            if (j == pulse_at) fsync = 1'b1;
            if (j == pulse_at + 1) fsync = 1'b0;
            if (chain_next && j == ntot - 2) fsync = ~fsync;
            lastlen = lk;
            j++;
         end
      end
      step();
      chk("R6", "last rx_valid", int'(rx_valid), 1);
      chk("R6", "last rx_word", int'(rx_word), gen_w(seed + 100, wn - 1, lastlen));
      chk("R8", "frame_done", int'(frame_done), 1);
      chk("R8", "frame_active at end", int'(frame_active), int'(chain_next));
      if (!chain_next) begin
         step();
         chk("R8", "frame_done one cycle", int'(frame_done), 0);
         step();
         chk((pulse_at >= 0) ? "R7" : "R8", "stays idle", int'(frame_active), 0);
         chk("R8", "sdo idle", int'(sdo), 0);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk("R1", "sdo", int'(sdo), 0);
      chk("R1", "frame_active", int'(frame_active), 0);
      chk("R1", "frame_done", int'(frame_done), 0);
      chk("R1", "rx_valid", int'(rx_valid), 0);
      chk("R1", "tx_take", int'(tx_take), 0);
   endtask

   task automatic t_multi();
      run_frame("R2", 2'b00, 12, 2, 3, 1'b0, 1'b0, -1);
   endtask

   task automatic t_lockout();
      run_frame("R7", 2'b00, 8, 4, 11, 1'b0, 1'b0, 2);
   endtask

   task automatic t_aclink();
      run_frame("R4", 2'b10, 8, 3, 21, 1'b0, 1'b0, -1);
   endtask

   task automatic t_i2s_pair();
      fsync = 1'b0;
      step(); step();
      run_frame("R3", 2'b01, 16, 1, 5, 1'b0, 1'b1, -1);
      run_frame("R3", 2'b01, 16, 1, 6, 1'b1, 1'b0, -1);
   endtask

   task automatic t_clamp();
      fsync = 1'b0;
      step(); step();
      run_frame("R10", 2'b00, 2, 0, 31, 1'b0, 1'b0, -1);
      run_frame("R10", 2'b00, 31, 2, 41, 1'b0, 1'b0, -1);
   endtask

   task automatic t_reserved();
      cfg_mode = 2'b11;
      step();
      fsync = 1'b1;
      step();
      fsync = 1'b0;
      for (int i = 0; i < 4; i++) begin
         step();
         chk("R11", "no frame in reserved mode", int'(frame_active), 0);
      end
      cfg_mode = 2'b00;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_multi();
      t_lockout();
      t_aclink();
      t_i2s_pair();
      t_clamp();
      t_reserved();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule